// File: doc/BRIEF.md
# Programmable Run-Ahead Prefetch Engine

This block sits next to a processor pipeline and turns software-programmed hints into cache prefetch requests. Software loads a small table with fill commands. Each entry names an instruction address that acts as a trigger, a current prefetch address, a signed step, a divisor and a warm-up skip count. The committed program counter is then compared against every valid entry on each cycle.

When a trigger matches, the divisor and the skip count decide whether this match produces a prefetch. If it does, the entry's current address is placed in a small request queue toward the cache and memory side, and the stored address moves on by the step. The queue presents requests with a valid/ready handshake. A synchronous clear empties the table and the queue together.

Top module: `prefetch_runahead`

## Requirements
- R1: A fill command (`fill_valid` high for one cycle) loads one table entry with trigger, base, stride, divisor and skip. The entry's match counter starts from zero after the fill.
- R2: A fill picks its target entry in this order. First, the valid entry whose trigger equals the fill trigger. Otherwise, the lowest-indexed invalid entry. When all entries are valid and none matches, entry 0 is overwritten. Trigger addresses in the table are therefore unique.
- R3: An entry reacts only in a cycle where `pc_valid` is high and `pc` equals its trigger. In any cycle at most one entry fires.
- R4: With divisor D, every D-th trigger match after the fill is a qualifying event. A divisor of 0 behaves like 1, which makes every match qualify.
- R5: With skip S, the first S qualifying events produce no request and leave the base unchanged. Later qualifying events fire.
- R6: A firing entry enqueues its current base. The base then becomes base + stride, where stride is two's complement and the sum wraps modulo 2^AW.
- R7: The request queue is first-in first-out and QDEPTH (4) deep, and it is empty after reset. `req_valid` is high whenever it holds an item, with the oldest item on `req_addr`. A request is removed when `req_valid` and `req_ready` are both high at a clock edge. While it waits unaccepted, `req_addr` is held.
- R8: A request that fires while the queue holds QDEPTH items is dropped, but the entry's base and counters still advance. Free space is judged on the occupancy at the start of the cycle, so a pop in the same cycle does not make room.
- R9: `clear` invalidates every entry and empties the queue at the next edge. It takes priority over a fill in the same cycle.
- R10: A fill that writes an entry in the same cycle as that entry's trigger match wins. The entry issues nothing in that cycle, and it starts afresh from the filled values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous clear of table and queue |
| fill_valid | input | 1 | Fill command strobe |
| fill_trig | input | PW | Trigger instruction address |
| fill_base | input | AW | First prefetch address |
| fill_stride | input | AW | Signed address step |
| fill_div | input | CW | Match divisor |
| fill_skip | input | CW | Qualifying events to skip |
| pc_valid | input | 1 | Program counter is valid this cycle |
| pc | input | PW | Committed program counter |
| req_valid | output | 1 | Prefetch request available |
| req_ready | input | 1 | Cache side accepts the request |
| req_addr | output | AW | Prefetch address |

## Verification
The bench drives a negative stride with a divisor of 4 and a skip of 1. A design that counted matches wrongly, or that advanced the base on skipped events, would emit the first address too early or emit a shifted address. It refills an existing trigger and then overflows a full table. A wrong placement rule shows up either as a duplicate request from one trigger or as a stale entry that still fires. It also overfills the stalled queue and then checks the address that follows. A design that froze the entry on a drop would repeat an old address instead of skipping ahead. Clear-with-fill and fill-with-match collisions are exercised as well, because a wrong priority in either case leaks a stray request.

// File: rtl/prefetch_runahead.sv
module prefetch_runahead #(
  parameter int AW      = 32,
  parameter int PW      = 32,
  parameter int ENTRIES = 4,
  parameter int QDEPTH  = 4,
  parameter int CW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          fill_valid,
  input  logic [PW-1:0] fill_trig,
  input  logic [AW-1:0] fill_base,
  input  logic [AW-1:0] fill_stride,
  input  logic [CW-1:0] fill_div,
  input  logic [CW-1:0] fill_skip,
  input  logic          pc_valid,
  input  logic [PW-1:0] pc,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr
);
  localparam int EI = $clog2(ENTRIES);
  localparam int QI = $clog2(QDEPTH);
  localparam int QC = $clog2(QDEPTH + 1);

  logic [ENTRIES-1:0] ent_v;
  logic [PW-1:0] ent_trig   [ENTRIES];
  logic [AW-1:0] ent_base   [ENTRIES];
  logic [AW-1:0] ent_stride [ENTRIES];
  logic [CW-1:0] ent_div    [ENTRIES];
  logic [CW-1:0] ent_skip   [ENTRIES];
  logic [CW-1:0] ent_cnt    [ENTRIES];

  logic [AW-1:0] q_mem [QDEPTH];
  logic [QI-1:0] q_wr, q_rd;
  logic [QC-1:0] q_cnt;

  logic [ENTRIES-1:0] hit, qual, fire, fill_we;
  logic [EI-1:0]      fsel;
  logic [AW-1:0]      fire_addr;
  logic               push, pop;

  always_comb begin
    logic got;
    got  = 1'b0;
    fsel = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (!got && ent_v[i] && ent_trig[i] == fill_trig) begin
        fsel = EI'(i);
        got  = 1'b1;
      end
    for (int i = 0; i < ENTRIES; i++)
      if (!got && !ent_v[i]) begin
        fsel = EI'(i);
        got  = 1'b1;
      end
  end

  always_comb begin
    fire_addr = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      fill_we[i] = fill_valid && !clear && fsel == EI'(i);
      hit[i]     = pc_valid && ent_v[i] && ent_trig[i] == pc;
      qual[i]    = hit[i] && (({1'b0, ent_cnt[i]} + 1'b1) >= {1'b0, ent_div[i]});
      fire[i]    = qual[i] && ent_skip[i] == '0 && !fill_we[i];
      if (fire[i]) fire_addr = fire_addr | ent_base[i];
    end
  end

  assign pop       = req_valid && req_ready;
  assign push      = (|fire) && q_cnt != QC'(QDEPTH);
  assign req_valid = q_cnt != '0;
  assign req_addr  = q_mem[q_rd];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        ent_trig[i]   <= '0;
        ent_base[i]   <= '0;
        ent_stride[i] <= '0;
        ent_div[i]    <= '0;
        ent_skip[i]   <= '0;
        ent_cnt[i]    <= '0;
      end
    end else if (clear) begin
      ent_v <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (fill_we[i]) begin
          ent_v[i]      <= 1'b1;
          ent_trig[i]   <= fill_trig;
          ent_base[i]   <= fill_base;
          ent_stride[i] <= fill_stride;
          ent_div[i]    <= fill_div;
          ent_skip[i]   <= fill_skip;
          ent_cnt[i]    <= '0;
        end else if (hit[i]) begin
          if (qual[i]) begin
            ent_cnt[i] <= '0;
            if (ent_skip[i] != '0) ent_skip[i] <= ent_skip[i] - 1'b1;
            else                   ent_base[i] <= ent_base[i] + ent_stride[i];
          end else begin
            ent_cnt[i] <= ent_cnt[i] + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_wr  <= '0;
      q_rd  <= '0;
      q_cnt <= '0;
      for (int k = 0; k < QDEPTH; k++) q_mem[k] <= '0;
    end else if (clear) begin
      q_wr  <= '0;
      q_rd  <= '0;
      q_cnt <= '0;
    end else begin
      if (push) begin
        q_mem[q_wr] <= fire_addr;
        q_wr        <= q_wr + 1'b1;
      end
      if (pop) q_rd <= q_rd + 1'b1;
      q_cnt <= q_cnt + QC'(push) - QC'(pop);
    end
  end
endmodule

module prefetch_runahead_chk #(
  parameter int AW      = 32,
  parameter int ENTRIES = 4,
  parameter int QDEPTH  = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         clear,
  input logic                         pc_valid,
  input logic [ENTRIES-1:0]           fire,
  input logic [$clog2(QDEPTH+1)-1:0]  q_cnt,
  input logic                         req_valid,
  input logic                         req_ready,
  input logic [AW-1:0]                req_addr
);
  localparam int QC = $clog2(QDEPTH + 1);

  assert_single_fire_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire));

  assert_fire_needs_pc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|fire) |-> pc_valid);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= QC'(QDEPTH));

  assert_head_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !clear) |=> (req_valid && $stable(req_addr)));

  assert_clear_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !req_valid);
endmodule

bind prefetch_runahead prefetch_runahead_chk #(
  .AW(AW), .ENTRIES(ENTRIES), .QDEPTH(QDEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clear(clear), .pc_valid(pc_valid),
  .fire(fire), .q_cnt(q_cnt), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr)
);

// File: tb/test_prefetch_runahead.sv
`timescale 1ns/1ps
module test_prefetch_runahead;
  localparam int AW = 32, PW = 32, CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear = 1'b0;
  logic          fill_valid = 1'b0;
  logic [PW-1:0] fill_trig = '0;
  logic [AW-1:0] fill_base = '0, fill_stride = '0;
  logic [CW-1:0] fill_div = '0, fill_skip = '0;
  logic          pc_valid = 1'b0;
  logic [PW-1:0] pc = '0;
  logic          req_valid, req_ready = 1'b1;
  logic [AW-1:0] req_addr;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [AW-1:0] exp_addr[$];
  string         exp_tag[$];

  prefetch_runahead i_prefetch_runahead (
    .clk(clk), .rst_n(rst_n), .clear(clear), .fill_valid(fill_valid),
    .fill_trig(fill_trig), .fill_base(fill_base), .fill_stride(fill_stride),
    .fill_div(fill_div), .fill_skip(fill_skip), .pc_valid(pc_valid), .pc(pc),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr)
  );

  always #4 clk = ~clk;

  task automatic check(bit ok, string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      if (exp_addr.size() == 0) begin
        check(1'b0, "unexpected request", req_addr, '0);
      end else begin
        logic [AW-1:0] e;
        string t;
        e = exp_addr.pop_front();
        t = exp_tag.pop_front();
        check(req_addr == e, t, req_addr, e);
      end
    end
  end

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic expect_req(logic [AW-1:0] a, string tag);
    exp_addr.push_back(a);
    exp_tag.push_back(tag);
  endtask

  task automatic fill(logic [PW-1:0] t, logic [AW-1:0] b, logic [AW-1:0] s,
                      logic [CW-1:0] d, logic [CW-1:0] k);
    fill_valid = 1'b1; fill_trig = t; fill_base = b;
    fill_stride = s; fill_div = d; fill_skip = k;
    step();
    fill_valid = 1'b0;
  endtask

  task automatic hit(logic [PW-1:0] p, int n = 1);
    for (int k = 0; k < n; k++) begin
      pc_valid = 1'b1; pc = p;
      step();
      pc_valid = 1'b0;
    end
  endtask

  task automatic expect_idle(string tag);
    @(negedge clk);
    check(req_valid == 1'b0, tag, AW'(req_valid), '0);
  endtask

  localparam logic [PW-1:0] TA = 'h400, TB = 'h404, TC = 'h408, TD = 'h40C,
                            TE = 'h410, TF = 'h414, TG = 'h418, TH = 'h41C;

  initial begin
    step(3);
    rst_n = 1'b1;
    step();
    expect_idle("R7 reset queue empty");

    // R1 R6: positive stride, every match fires
    fill(TA, 'h1000, 400, 1, 0);
    expect_req('h1000, "R1 first address");
    expect_req('h1190, "R6 base+400");
    expect_req('h1320, "R6 base+800");
    hit(TA, 3);
    step(2);

    // R3: wrong pc, and right pc without valid
    pc_valid = 1'b1; pc = TB; step(); pc_valid = 1'b0;
    expect_idle("R3 other pc ignored");
    pc = TA; step();
    expect_idle("R3 pc_valid low ignored");
    expect_req('h14B0, "R3 base unchanged by ignored pcs");
    hit(TA);
    step(2);

    // R4 R5: negative stride, divisor 4, skip 1
    fill(TB, 'h2010, -4, 4, 1);
    hit(TB, 4);
    expect_idle("R5 first qualifying event skipped");
    hit(TB, 3);
    expect_idle("R4 non-qualifying matches");
    expect_req('h2010, "R5 skip leaves base");
    hit(TB);
    expect_req('h200C, "R6 negative stride");
    hit(TB, 4);
    step(2);

    // R2: replace, fill free entries, then overwrite entry 0
    fill(TA, 'h5000, 0, 1, 0);
    expect_req('h5000, "R2 refill replaces same trigger");
    hit(TA);
    step(2);
    fill(TC, 'h6000, 0, 1, 0);
    fill(TD, 'h7000, 0, 1, 0);
    fill(TE, 'h8000, 0, 1, 0);
    hit(TA);
    expect_idle("R2 full table overwrote entry 0");
    expect_req('h8000, "R2 new entry in slot 0");
    hit(TE);
    expect_req('h6000, "R2 other entries intact");
    hit(TC);
    expect_req('h2008, "R2 entry 1 intact");
    hit(TB, 4);
    step(2);

    // R8: stalled queue overflows, entry still advances
    clear = 1'b1; step(); clear = 1'b0;
    req_ready = 1'b0;
    fill(TF, 'h100, 'h10, 1, 0);
    for (int k = 0; k < 4; k++) expect_req(AW'('h100 + 'h10 * k), "R8 queued before full");
    hit(TF, 6);
    @(negedge clk);
    check(req_valid && req_addr == 'h100, "R7 head held while stalled", req_addr, 'h100);
    step(3);
    @(negedge clk);
    check(req_valid && req_addr == 'h100, "R7 head still held", req_addr, 'h100);
    req_ready = 1'b1;
    step(6);
    expect_idle("R8 only queue depth kept");
    expect_req('h160, "R8 dropped requests still advanced base");
    hit(TF);
    step(2);

    // R9: clear empties queue, invalidates, beats a fill
    req_ready = 1'b0;
    hit(TF, 2);
    @(negedge clk);
    check(req_valid == 1'b1, "R9 queue loaded before clear", AW'(req_valid), 1);
    clear = 1'b1; step(); clear = 1'b0;
    req_ready = 1'b1;
    expect_idle("R9 queue emptied");
    hit(TF);
    expect_idle("R9 entry invalidated");
    clear = 1'b1; fill(TG, 'hC000, 0, 1, 0); clear = 1'b0;
    hit(TG);
    expect_idle("R9 clear wins over fill");

    // R10 R4: fill and trigger in the same cycle, divisor 0
    fill(TH, 'h9000, 8, 0, 0);
    fill_valid = 1'b1; fill_trig = TH; fill_base = 'hA000; fill_stride = 8;
    fill_div = 0; fill_skip = 0; pc_valid = 1'b1; pc = TH;
    step();
    fill_valid = 1'b0; pc_valid = 1'b0;
    expect_idle("R10 fill wins over match");
    expect_req('hA000, "R10 new base used");
    expect_req('hA008, "R4 divisor 0 fires every match");
    hit(TH, 2);
    step(3);

    check(exp_addr.size() == 0, "R7 all expected requests seen", AW'(exp_addr.size()), 0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  end
endmodule